// File: doc/BRIEF.md
# Low-Light PWM Dimming Generator

This block turns a white-LED driver into a very dim light source. It produces a free-running on/off gate at a fixed 30 kHz. The gate's duty cycle is picked from a non-uniform table of eight settings, and the block applies that gate to each enabled high-power LED channel. The same 4-bit brightness code also serves a second, exclusive purpose. When its top bit is clear, the lower bits choose a drive level for a separate low-current indicator LED instead of a duty cycle.

Each function is gated by the operating state. PWM dimming runs only in the software video-light state with voltage mode enabled. The indicator level only comes out while the converter is shut down. While dimming is running, the block raises a flag that tells the video-light safety watchdog to stand down. Period length is a parameter derived from the system clock. Every duty threshold is rounded to the nearest clock count. New codes, enables and activations wait for the next period boundary, so no shortened pulse is ever produced.

Top module: `lowlight_pwm_top`

## Requirements
- R1: The period is P = round(CLK_HZ / PWM_HZ) clock cycles. While dimming is running, consecutive rising edges of any gate are exactly P cycles apart.
- R2: With code bits [3] = 1 and [2:0] = k, each enabled gate is high for round(P * pct[k] / 100) cycles at the start of every period, where pct for k = 0..7 is 5, 11, 17, 23, 30, 36, 48, 67.
- R3: Dimming is active only when the mode field is 2'b01, voltage-mode enable is 1 and code bit [3] is 1. Otherwise every gate output is low.
- R4: Gate output i can be high only when LED enable bit i was set at the start of the current period.
- R5: Changes to code bits [2:0], the LED enables, or the transition into the active condition take effect only at the next period boundary. A gate therefore only rises in the first cycle of a period. Leaving the active condition drives all gates low in the same cycle.
- R6: The watchdog-disable output is high exactly while the active condition of R3 holds.
- R7: One cycle after the inputs are applied, the indicator level output encodes 0 = off, 1 = 2.6 mA, 2 = 5.2 mA, 3 = 7.9 mA, 4 = 10.4 mA, 5 = 15.8 mA. In mode 2'b00 with voltage-mode enable 0 and code bit [3] = 0, code [2:0] = 0..7 maps to 0,1,2,3,0,2,4,5. In every other case the output is 0.
- R8: During reset all gates and the indicator level are 0, and the period restarts from its first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| dimCode | input | 4 | Shared brightness code: bit 3 set selects a duty cycle, clear selects an indicator level |
| opMode | input | 2 | Operating-mode field (2'b01 video light, 2'b00 shutdown) |
| voltModeEn | input | 1 | Voltage-mode enable |
| ledEnable | input | NUM_LED | Per-channel white-LED enables |
| ledGate | output | NUM_LED | Per-channel PWM gate |
| indLevel | output | 3 | Indicator drive level code |
| wdogOff | output | 1 | High while dimming is running; disables the video-light watchdog |

## Verification
The hardest situation to reach is an input change in the middle of a period. A code, enable or mode change made then must neither cut the current pulse short nor start a late one, while an exit from the active state must still act at once. The stimulus alters the inputs on random cycles with a low probability, biased toward the active state, so many changes fall at arbitrary counter phases. Some of these are exits and re-entries within one period. A cycle-level bench model that latches settings only at its own period boundary predicts every gate, the watchdog flag and the indicator level.

// File: rtl/lowlight_pwm_pkg.sv
package lowlight_pwm_pkg;

  localparam int unsigned DUTY_STEPS = 8;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic       gateOk;   // latched arm AND live active condition
    logic [2:0] dutySel;  // duty table index latched at period start
  } dim_ctrl_t;

  // Duty percentage for each step of the non-uniform table
  function automatic int unsigned dutyPct(input int unsigned idx);
    case (idx)
      0: dutyPct = 5;
      1: dutyPct = 11;
      2: dutyPct = 17;
      3: dutyPct = 23;
      4: dutyPct = 30;
      5: dutyPct = 36;
      6: dutyPct = 48;
      default: dutyPct = 67;
    endcase
  endfunction

  // Indicator level code from the lower three code bits
  function automatic logic [2:0] indDecode(input logic [2:0] sel);
    case (sel)
      3'd1: indDecode = 3'd1;
      3'd2: indDecode = 3'd2;
      3'd3: indDecode = 3'd3;
      3'd5: indDecode = 3'd2;
      3'd6: indDecode = 3'd4;
      3'd7: indDecode = 3'd5;
      default: indDecode = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/lowlight_pwm_ctrl.sv
module lowlight_pwm_ctrl
  import lowlight_pwm_pkg::*;
#(
  parameter int unsigned NUM_LED = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         dimCode,
  input  logic [1:0]         opMode,
  input  logic               voltModeEn,
  input  logic [NUM_LED-1:0] ledEnable,
  input  logic               periodEnd,
  output dim_ctrl_t          ctrl,
  output logic [NUM_LED-1:0] chanMask,
  output logic [2:0]         indLevel,
  output logic               wdogOff
);

  localparam logic [1:0] MODE_VIDEO = 2'b01;
  localparam logic [1:0] MODE_OFF   = 2'b00;

  logic              livePwm;
  logic              shutdownInd;
  logic              armQ;
  logic [2:0]        selQ;
  logic [NUM_LED-1:0] maskQ;
  logic [2:0]        indQ;

  assign livePwm     = (opMode == MODE_VIDEO) && voltModeEn && dimCode[3];
  assign shutdownInd = (opMode == MODE_OFF) && !voltModeEn && !dimCode[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ  <= 1'b0;
      selQ  <= '0;
      maskQ <= '0;
      indQ  <= '0;
    end else begin
      if (periodEnd) begin
        armQ  <= livePwm;
        selQ  <= dimCode[2:0];
        maskQ <= ledEnable;
      end else begin
        armQ  <= armQ & livePwm;
      end
      indQ <= shutdownInd ? indDecode(dimCode[2:0]) : 3'd0;
    end
  end

  assign ctrl.gateOk  = armQ & livePwm;
  assign ctrl.dutySel = selQ;
  assign chanMask     = maskQ;
  assign indLevel     = indQ;
  assign wdogOff      = livePwm;

  // Duty selection only moves on a period boundary
  p_sel_at_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selQ) |-> $past(periodEnd));

  // Channel mask only moves on a period boundary
  p_mask_at_boundary_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(maskQ) |-> $past(periodEnd));

  // Indicator stays off outside the shutdown state
  p_ind_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    !((opMode == MODE_OFF) && !voltModeEn) |=> (indLevel == 3'd0));

endmodule

// File: rtl/lowlight_pwm_datapath.sv
module lowlight_pwm_datapath
  import lowlight_pwm_pkg::*;
#(
  parameter int unsigned PERIOD  = 100,
  parameter int unsigned NUM_LED = 3,
  localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dim_ctrl_t          ctrl,
  input  logic [NUM_LED-1:0] chanMask,
  output logic               periodEnd,
  output logic [NUM_LED-1:0] gate
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thrTab [DUTY_STEPS];
  logic             underThr;

  // Thresholds rounded to the nearest count
  for (genvar g = 0; g < DUTY_STEPS; g++) begin : g_thr
    assign thrTab[g] = CNT_W'((PERIOD * dutyPct(g) + 50) / 100);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (periodEnd) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign periodEnd = (cnt == LAST);
  assign underThr  = (cnt < thrTab[ctrl.dutySel]);

  for (genvar i = 0; i < NUM_LED; i++) begin : g_ch
    assign gate[i] = ctrl.gateOk & chanMask[i] & underThr;

    // A gate never starts mid-period
    p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gate[i]) |-> (cnt == '0));
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (cnt == '0));

endmodule

// File: rtl/lowlight_pwm_top.sv
module lowlight_pwm_top
  import lowlight_pwm_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned PWM_HZ  = 30_000,
  parameter int unsigned NUM_LED = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         dimCode,
  input  logic [1:0]         opMode,
  input  logic               voltModeEn,
  input  logic [NUM_LED-1:0] ledEnable,
  output logic [NUM_LED-1:0] ledGate,
  output logic [2:0]         indLevel,
  output logic               wdogOff
);

  localparam int unsigned PERIOD = (CLK_HZ + PWM_HZ / 2) / PWM_HZ;

  dim_ctrl_t          ctrl;
  logic [NUM_LED-1:0] chanMask;
  logic               periodEnd;

  lowlight_pwm_ctrl #(.NUM_LED(NUM_LED)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dimCode   (dimCode),
    .opMode    (opMode),
    .voltModeEn(voltModeEn),
    .ledEnable (ledEnable),
    .periodEnd (periodEnd),
    .ctrl      (ctrl),
    .chanMask  (chanMask),
    .indLevel  (indLevel),
    .wdogOff   (wdogOff)
  );

  lowlight_pwm_datapath #(.PERIOD(PERIOD), .NUM_LED(NUM_LED)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .chanMask (chanMask),
    .periodEnd(periodEnd),
    .gate     (ledGate)
  );

  // Any lit gate implies the watchdog is held off
  p_gate_implies_wdog_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|ledGate) |-> wdogOff);

endmodule

// File: tb/lowlight_pwm_top_test.sv
`timescale 1ns/1ps
module lowlight_pwm_top_test;

  localparam int unsigned CLK_HZ  = 3_000_000;
  localparam int unsigned PWM_HZ  = 30_000;
  localparam int unsigned NUM_LED = 3;
  localparam int unsigned P       = (CLK_HZ + PWM_HZ / 2) / PWM_HZ;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [3:0]         dimCode = 4'd0;
  logic [1:0]         opMode = 2'b00;
  logic               voltModeEn = 1'b0;
  logic [NUM_LED-1:0] ledEnable = '0;
  logic [NUM_LED-1:0] ledGate;
  logic [2:0]         indLevel;
  logic               wdogOff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state
  int unsigned        mCnt = 0;
  bit                 mArm = 1'b0;
  int unsigned        mSel = 0;
  logic [NUM_LED-1:0] mEn  = '0;
  logic [2:0]         mInd = '0;

  lowlight_pwm_top #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ), .NUM_LED(NUM_LED)) uut (
    .clk(clk), .rstN(rstN), .dimCode(dimCode), .opMode(opMode),
    .voltModeEn(voltModeEn), .ledEnable(ledEnable),
    .ledGate(ledGate), .indLevel(indLevel), .wdogOff(wdogOff)
  );

  always #2 clk = ~clk;

  function automatic int unsigned expThr(input int unsigned sel);
    int unsigned pct;
    case (sel)
      0: pct = 5;   1: pct = 11;  2: pct = 17;  3: pct = 23;
      4: pct = 30;  5: pct = 36;  6: pct = 48;  default: pct = 67;
    endcase
    return (P * pct + 50) / 100;
  endfunction

  function automatic logic [2:0] expInd(input logic [3:0] c, input logic [1:0] m,
                                        input logic v);
    if (m != 2'b00 || v || c[3]) return 3'd0;
    case (c[2:0])
      3'd1: return 3'd1;  3'd2: return 3'd2;  3'd3: return 3'd3;
      3'd5: return 3'd2;  3'd6: return 3'd4;  3'd7: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic bit liveOn();
    return (opMode == 2'b01) && voltModeEn && dimCode[3];
  endfunction

  // Model advances on the same edge as the design, from the inputs only
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mArm = 0; mSel = 0; mEn = '0; mInd = '0;
    end else begin
      if (mCnt == P - 1) begin
        mCnt = 0;
        mArm = liveOn();
        mSel = dimCode[2:0];
        mEn  = ledEnable;
      end else begin
        mCnt = mCnt + 1;
        mArm = mArm && liveOn();
      end
      mInd = expInd(dimCode, opMode, voltModeEn);
    end
  end

  task automatic checkVal(input string tag, input string what,
                          input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, actual, expected, $time);
    end
  endtask

  // Compare all outputs with the model; called at a falling edge
  task automatic checkAll();
    logic [NUM_LED-1:0] eg;
    string tag;
    for (int i = 0; i < NUM_LED; i++)
      eg[i] = mArm && liveOn() && mEn[i] && (mCnt < expThr(mSel));
    if (!liveOn()) tag = "R3";
    else if (!mArm || dimCode[2:0] != mSel[2:0] || ledEnable != mEn) tag = "R5";
    else if (mEn != '1) tag = "R4";
    else tag = "R2";
    checkVal(tag, "ledGate", int'(ledGate), int'(eg));
    checkVal("R6", "wdogOff", int'(wdogOff), int'(liveOn()));
    checkVal("R7", "indLevel", int'(indLevel), int'(mInd));
  endtask

  task automatic setIn(input logic [3:0] c, input logic [1:0] m, input logic v,
                       input logic [NUM_LED-1:0] e);
    dimCode = c; opMode = m; voltModeEn = v; ledEnable = e;
  endtask

  task automatic runCycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      checkAll();
    end
  endtask

  initial begin
    int lastRise;
    int cyc;
    logic [NUM_LED-1:0] prevG;
    void'($urandom(32'h5A17));

    // R8: reset state with inputs that would otherwise light outputs
    setIn(4'b1111, 2'b01, 1'b1, '1);
    repeat (3) begin
      @(negedge clk);
      checkVal("R8", "ledGate in reset", int'(ledGate), 0);
      checkVal("R8", "indLevel in reset", int'(indLevel), 0);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1: rise-to-rise spacing at the longest duty
    lastRise = -1; cyc = 0; prevG = '0;
    for (int k = 0; k < 6 * P; k++) begin
      @(negedge clk);
      checkAll();
      if (ledGate[0] && !prevG[0]) begin
        if (lastRise >= 0) checkVal("R1", "rise spacing", cyc - lastRise, int'(P));
        lastRise = cyc;
      end
      prevG = ledGate;
      cyc++;
    end

    // R2: shortest duty, then all steps directed
    for (int s = 0; s < 8; s++) begin
      setIn({1'b1, 3'(s)}, 2'b01, 1'b1, '1);
      runCycles(2 * P);
    end

    // R4: single channel enabled
    setIn(4'b1110, 2'b01, 1'b1, 3'b010);
    runCycles(2 * P);

    // R5: mid-period exit and re-entry
    runCycles(P / 3);
    setIn(4'b1110, 2'b10, 1'b1, 3'b010);
    runCycles(3);
    setIn(4'b1110, 2'b01, 1'b1, 3'b010);
    runCycles(2 * P);

    // R7: every indicator code in shutdown, then with voltage mode set
    for (int c = 0; c < 16; c++) begin
      setIn(4'(c), 2'b00, 1'b0, '0);
      runCycles(3);
    end
    setIn(4'b0111, 2'b00, 1'b1, '0);
    runCycles(3);

    // R3: wrong mode combinations
    setIn(4'b1111, 2'b11, 1'b1, '1);
    runCycles(P);
    setIn(4'b1111, 2'b01, 1'b0, '1);
    runCycles(P);
    setIn(4'b0110, 2'b01, 1'b1, '1);
    runCycles(P);

    // Random phase, biased toward the active state
    for (int k = 0; k < 30000; k++) begin
      @(negedge clk);
      checkAll();
      if ($urandom_range(0, 29) == 0) begin
        logic [1:0] m;
        logic v;
        logic [3:0] c;
        c = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 9) < 6) begin m = 2'b01; v = 1'b1; c[3] = 1'b1; end
        else begin m = 2'($urandom_range(0, 3)); v = 1'($urandom_range(0, 1)); end
        setIn(c, m, v, NUM_LED'($urandom_range(0, (1 << NUM_LED) - 1)));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule